// File: doc/BRIEF.md
# Hidden Refresh Cycle Controller

This block holds the refresh state for a DRAM whose rows are mirrored in per-bank row registers. It watches the row-enable strobe, sampled on the system clock. It turns two kinds of cycle into refresh commands for the array sequencer:

- **Internal refresh.** The refresh strobe is low when row enable falls. The row comes from an internal counter, which steps forward when the cycle closes.
- **External-address refresh.** A selected write-type cycle runs with the column strobe high the whole time. It refreshes the row given on the address pins, and the top address bit is ignored.

Neither kind of cycle may disturb the row registers or their last-row tags. While such a cycle is open, the block keeps the cache row-load enable off. Cache reads go on in parallel, because the block never touches the column path.

A scheduler raises one refresh request per slot. The retention period is divided evenly over the number of rows to give the slot length. Unserved slots pile up in a small saturating counter. An overdue flag compares that count with a limit set by software.

Refresh commands leave on a valid/ready stream. `rf_valid` stays high, with `rf_row` and `rf_ext` frozen, until a cycle with `rf_ready` high accepts it. Commands are delivered in the order they were issued. Up to `Q_DEPTH` commands are held. The bus must not start more refresh cycles than that while the sink stalls, or the excess command is lost.

Top module: `hidref_ctrl`

## Requirements
- R1: A row-enable falling edge with `refresh_n` low issues one command with `rf_ext`=0 and `rf_row` equal to the internal counter. This holds whatever `select_n` and `wr_rd` are.
- R2: The internal row counter is 0 after reset. It advances by one, wrapping modulo 2^ROW_W, each time an internal refresh cycle ends (row enable returns high).
- R3: A cycle that starts with `refresh_n` high, `select_n` low and `wr_rd`=1 (write type), and keeps `col_strobe_n` high until row enable returns high, issues one command with `rf_ext`=1 and `rf_row`=`addr[ROW_W-1:0]`. `addr[ROW_W]` has no effect.
- R4: A write-type cycle during which `col_strobe_n` is low on any sampled clock issues no command. A read-type cycle (`wr_rd`=0) never issues a command.
- R5: A non-refresh cycle started with `select_n` high is ignored: no command, and `miss_load_en` stays low.
- R6: `miss_load_en` equals `miss_load_req` only while a selected read-type cycle is open, from the clock after the fall up to the rise. At all other times it is 0, including during both kinds of refresh cycle.
- R7: While `rf_valid` is high and `rf_ready` is low, `rf_valid`, `rf_row` and `rf_ext` hold. Commands are delivered in issue order, and none is lost within the queue depth.
- R8: Each slot of PERIOD = CLK_MHZ*RETAIN_US/ROWS clocks adds one pending request, saturating at 2^PEND_W-1. Each internal refresh start removes one, never going below 0. A slot end and a refresh start in the same clock cancel out. `sched_req` is high exactly when the count is non-zero.
- R9: `sched_overdue` is high exactly when the pending count is at least `sched_limit`.
- R10: During reset, `rf_valid`, `sched_req` and `miss_load_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_en_n | input | 1 | Row enable, active low; a cycle runs from its fall to its rise |
| refresh_n | input | 1 | Refresh strobe, sampled at the row-enable fall |
| wr_rd | input | 1 | Cycle type at the fall: 1 write, 0 read |
| select_n | input | 1 | Device select, active low |
| col_strobe_n | input | 1 | Column strobe, active low |
| addr | input | ROW_W+1 | Row address; the top bit is not used for refresh |
| miss_load_req | input | 1 | Cache logic request to load a row register and tag |
| miss_load_en | output | 1 | Gated row-register load enable |
| rf_valid | output | 1 | Refresh command valid |
| rf_ready | input | 1 | Refresh command accepted by the sequencer |
| rf_row | output | ROW_W | Row to refresh |
| rf_ext | output | 1 | 1 = external-address refresh, 0 = internal counter |
| sched_limit | input | PEND_W | Pending count at which overdue is raised |
| sched_req | output | 1 | At least one refresh slot is unserved |
| sched_overdue | output | 1 | Pending count has reached the limit |

## Verification
The hardest state to reach is a saturated pending counter. It needs many slot periods with no internal refresh cycle on the bus. A close second is a slot end that lands in the same clock as a refresh start.

The bench shortens the slot to 128 clocks through parameters. It idles for more than eight slots to pin the count at its ceiling. It then issues one refresh to step back off it. The random phase mixes cycle kinds with random gaps and a stalling ready, so that coincidences between slot ends and refresh starts arise without being aimed at.

A 4-bit counter makes wrap-around occur within the run.

// File: rtl/hidref_pkg.sv
package hidref_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE  = 3'd0,
    CYC_READ  = 3'd1,
    CYC_WRITE = 3'd2,
    CYC_IREF  = 3'd3,
    CYC_SKIP  = 3'd4
  } cyc_e;

endpackage

// File: rtl/hidref_decode.sv
module hidref_decode
  import hidref_pkg::*;
#(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_en_n,
  input  logic             refresh_n,
  input  logic             wr_rd,
  input  logic             select_n,
  input  logic             col_strobe_n,
  input  logic [ROW_W-1:0] row_addr,
  input  logic             miss_load_req,
  output logic             miss_load_en,
  output logic             iref_start,
  output logic             iref_end,
  output logic             xref_fire,
  output logic [ROW_W-1:0] xref_row,
  output cyc_e             cyc_o
);

  logic             ren_q;
  logic             col_seen_q;
  cyc_e             cyc_q;
  logic [ROW_W-1:0] xrow_q;
  logic             fall;
  logic             rise;
  cyc_e             cyc_new;

  assign fall = ren_q & ~row_en_n;
  assign rise = ~ren_q & row_en_n;

  // Cycle class decided once, at the falling edge of row enable
  always_comb begin
    if (!refresh_n)    cyc_new = CYC_IREF;
    else if (select_n) cyc_new = CYC_SKIP;
    else if (wr_rd)    cyc_new = CYC_WRITE;
    else               cyc_new = CYC_READ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ren_q      <= 1'b1;
      cyc_q      <= CYC_IDLE;
      col_seen_q <= 1'b0;
      xrow_q     <= '0;
    end else begin
      ren_q <= row_en_n;
      if (fall) begin
        cyc_q      <= cyc_new;
        col_seen_q <= ~col_strobe_n;
        xrow_q     <= row_addr;
      end else if (rise) begin
        cyc_q      <= CYC_IDLE;
        col_seen_q <= 1'b0;
      end else if (cyc_q != CYC_IDLE && !col_strobe_n) begin
        col_seen_q <= 1'b1;
      end
    end
  end

  assign iref_start   = fall & ~refresh_n;
  assign iref_end     = rise & (cyc_q == CYC_IREF);
  assign xref_fire    = rise & (cyc_q == CYC_WRITE) & ~col_seen_q & col_strobe_n;
  assign xref_row     = xrow_q;
  assign miss_load_en = miss_load_req & (cyc_q == CYC_READ);
  assign cyc_o        = cyc_q;

endmodule

// File: rtl/hidref_rowctr.sv
module hidref_rowctr #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [ROW_W-1:0] row
);

  logic [ROW_W-1:0] ctr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       ctr_q <= '0;
    else if (advance) ctr_q <= ctr_q + 1'b1;
  end

  assign row = ctr_q;

endmodule

// File: rtl/hidref_sched.sv
module hidref_sched #(
  parameter int PERIOD = 12500,
  parameter int PEND_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              credit,
  input  logic [PEND_W-1:0] limit,
  output logic              req,
  output logic              overdue,
  output logic [PEND_W-1:0] pend
);

  localparam int TW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [TW-1:0]     TLAST = TW'(PERIOD - 1);
  localparam logic [PEND_W-1:0] PMAX  = '1;

  logic [TW-1:0]     tcnt_q;
  logic [PEND_W-1:0] pend_q;
  logic              tick;

  assign tick = (tcnt_q == TLAST);

  always_ff @(posedge clk) begin
    if (!rst_n) tcnt_q <= '0;
    else if (tick) tcnt_q <= '0;
    else tcnt_q <= tcnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      case ({tick, credit})
        2'b10:   if (pend_q != PMAX) pend_q <= pend_q + 1'b1;
        2'b01:   if (pend_q != '0)   pend_q <= pend_q - 1'b1;
        default: pend_q <= pend_q;
      endcase
    end
  end

  assign req     = (pend_q != '0);
  assign overdue = (pend_q >= limit);
  assign pend    = pend_q;

endmodule

// File: rtl/hidref_cmdq.sv
module hidref_cmdq #(
  parameter int W     = 11,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   CAP  = (AW + 1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q;
  logic [AW-1:0] rp_q;
  logic [AW:0]   cnt_q;
  logic          do_push;
  logic          do_pop;

  assign full      = (cnt_q == CAP);
  assign out_valid = (cnt_q != '0);
  assign do_push   = push & ~full;
  assign do_pop    = out_valid & out_ready;
  assign out_data  = mem[rp_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/hidref_ctrl.sv
module hidref_ctrl
  import hidref_pkg::*;
#(
  parameter int ROW_W     = 10,
  parameter int CLK_MHZ   = 200,
  parameter int RETAIN_US = 64000,
  parameter int ROWS      = 1024,
  parameter int PEND_W    = 3,
  parameter int Q_DEPTH   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_en_n,
  input  logic              refresh_n,
  input  logic              wr_rd,
  input  logic              select_n,
  input  logic              col_strobe_n,
  input  logic [ROW_W:0]    addr,
  input  logic              miss_load_req,
  output logic              miss_load_en,
  output logic              rf_valid,
  input  logic              rf_ready,
  output logic [ROW_W-1:0]  rf_row,
  output logic              rf_ext,
  input  logic [PEND_W-1:0] sched_limit,
  output logic              sched_req,
  output logic              sched_overdue
);

  localparam int PERIOD = CLK_MHZ * RETAIN_US / ROWS;
  localparam int CMD_W  = ROW_W + 1;

  logic              iref_start;
  logic              iref_end;
  logic              xref_fire;
  logic [ROW_W-1:0]  xref_row;
  logic [ROW_W-1:0]  ctr_q;
  logic [PEND_W-1:0] pend_q;
  cyc_e              cyc_q;
  logic              q_push;
  logic              q_full;
  logic [CMD_W-1:0]  q_in;
  logic [CMD_W-1:0]  q_out;
  logic              addr_top_unused;

  assign addr_top_unused = addr[ROW_W];

  hidref_decode #(.ROW_W(ROW_W)) u_decode (
    .clk          (clk),
    .rst_n        (rst_n),
    .row_en_n     (row_en_n),
    .refresh_n    (refresh_n),
    .wr_rd        (wr_rd),
    .select_n     (select_n),
    .col_strobe_n (col_strobe_n),
    .row_addr     (addr[ROW_W-1:0]),
    .miss_load_req(miss_load_req),
    .miss_load_en (miss_load_en),
    .iref_start   (iref_start),
    .iref_end     (iref_end),
    .xref_fire    (xref_fire),
    .xref_row     (xref_row),
    .cyc_o        (cyc_q)
  );

  hidref_rowctr #(.ROW_W(ROW_W)) u_rowctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .advance(iref_end),
    .row    (ctr_q)
  );

  hidref_sched #(.PERIOD(PERIOD), .PEND_W(PEND_W)) u_sched (
    .clk    (clk),
    .rst_n  (rst_n),
    .credit (iref_start),
    .limit  (sched_limit),
    .req    (sched_req),
    .overdue(sched_overdue),
    .pend   (pend_q)
  );

  // Internal and external commands never coincide: one opens a cycle, the other closes one
  assign q_push = iref_start | xref_fire;
  assign q_in   = iref_start ? {1'b0, ctr_q} : {1'b1, xref_row};

  hidref_cmdq #(.W(CMD_W), .DEPTH(Q_DEPTH)) u_cmdq (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (q_push),
    .push_data(q_in),
    .full     (q_full),
    .out_valid(rf_valid),
    .out_ready(rf_ready),
    .out_data (q_out)
  );

  assign rf_ext = q_out[CMD_W-1];
  assign rf_row = q_out[ROW_W-1:0];

endmodule

// File: rtl/hidref_ctrl_chk.sv
module hidref_ctrl_chk
  import hidref_pkg::*;
#(
  parameter int ROW_W  = 10,
  parameter int PEND_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rf_valid,
  input logic              rf_ready,
  input logic [ROW_W-1:0]  rf_row,
  input logic              rf_ext,
  input logic              miss_load_en,
  input logic              miss_load_req,
  input cyc_e              cyc_q,
  input logic [ROW_W-1:0]  ctr_q,
  input logic [PEND_W-1:0] pend_q,
  input logic              q_push,
  input logic              q_full
);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid && !rf_ready) |=> (rf_valid && $stable(rf_row) && $stable(rf_ext)));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |-> !q_full);

  assert_ctr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_q != $past(ctr_q)) |-> (ctr_q == ROW_W'($past(ctr_q) + 1'b1)));

  assert_pend_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != $past(pend_q)) |->
      ((pend_q == PEND_W'($past(pend_q) + 1'b1)) || (pend_q == PEND_W'($past(pend_q) - 1'b1))));

  assert_refresh_no_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == CYC_IREF || cyc_q == CYC_WRITE || cyc_q == CYC_SKIP) |-> !miss_load_en);

  assert_load_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    miss_load_en |-> miss_load_req);

endmodule

bind hidref_ctrl hidref_ctrl_chk #(.ROW_W(ROW_W), .PEND_W(PEND_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rf_valid     (rf_valid),
  .rf_ready     (rf_ready),
  .rf_row       (rf_row),
  .rf_ext       (rf_ext),
  .miss_load_en (miss_load_en),
  .miss_load_req(miss_load_req),
  .cyc_q        (cyc_q),
  .ctr_q        (ctr_q),
  .pend_q       (pend_q),
  .q_push       (q_push),
  .q_full       (q_full)
);

// File: tb/hidref_ctrl_tb.sv
`timescale 1ns/1ps
module hidref_ctrl_tb;
  localparam int RW  = 4;
  localparam int PW  = 3;
  localparam int PER = 128;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          row_en_n = 1'b1, refresh_n = 1'b1, wr_rd = 1'b0, select_n = 1'b1;
  logic          col_strobe_n = 1'b1, miss_load_req = 1'b0, rf_ready = 1'b1;
  logic [RW:0]   addr = '0;
  logic [PW-1:0] sched_limit = 3'd7;
  logic          miss_load_en, rf_valid, rf_ext, sched_req, sched_overdue;
  logic [RW-1:0] rf_row;

  hidref_ctrl #(.ROW_W(RW), .CLK_MHZ(1), .RETAIN_US(2048), .ROWS(16),
                .PEND_W(PW), .Q_DEPTH(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .row_en_n(row_en_n), .refresh_n(refresh_n),
    .wr_rd(wr_rd), .select_n(select_n), .col_strobe_n(col_strobe_n), .addr(addr),
    .miss_load_req(miss_load_req), .miss_load_en(miss_load_en),
    .rf_valid(rf_valid), .rf_ready(rf_ready), .rf_row(rf_row), .rf_ext(rf_ext),
    .sched_limit(sched_limit), .sched_req(sched_req), .sched_overdue(sched_overdue));

  int n_chk = 0;
  int n_bad = 0;
  logic [RW:0]   expq[$];
  logic [RW-1:0] m_ctr = '0;
  int            m_tick = 0;
  int            m_pend = 0;
  logic          m_ren_prev = 1'b1;
  bit            rdy_rand = 1'b0;
  bit            hold_prev = 1'b0;
  logic [RW:0]   prev_cmd = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Scheduler reference: slot counter and saturating pending count (R8)
  always @(posedge clk) begin
    if (!rst_n) begin
      m_tick = 0; m_pend = 0; m_ren_prev = 1'b1;
    end else begin
      bit credit, tick;
      credit = m_ren_prev && !row_en_n && !refresh_n;
      tick   = (m_tick == PER - 1);
      m_tick = tick ? 0 : m_tick + 1;
      if (tick && !credit) begin
        if (m_pend < 7) m_pend++;
      end else if (!tick && credit && m_pend > 0) begin
        m_pend--;
      end
      m_ren_prev = row_en_n;
    end
  end

  always @(posedge clk) begin
    #1;
    rf_ready = rdy_rand ? ($urandom % 4 != 0) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(sched_req == (m_pend != 0), "R8 sched_req", sched_req, m_pend != 0);
      check(sched_overdue == (m_pend >= int'(sched_limit)), "R9 overdue",
            sched_overdue, m_pend >= int'(sched_limit));
      if (hold_prev)
        check(rf_valid && {rf_ext, rf_row} == prev_cmd, "R7 hold", {rf_ext, rf_row}, prev_cmd);
      if (rf_valid && rf_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R4 unexpected command", {rf_ext, rf_row}, 0);
        end else begin
          logic [RW:0] e;
          e = expq.pop_front();
          check({rf_ext, rf_row} == e, e[RW] ? "R3 ext cmd" : "R1 int cmd",
                {rf_ext, rf_row}, e);
        end
      end
      hold_prev = rf_valid && !rf_ready;
      prev_cmd  = {rf_ext, rf_row};
    end
  end

  // kind: 0 internal refresh, 1 write without column, 2 write with column, 3 read
  task automatic run_cycle(input int kind, input logic sel_n, input logic [RW:0] a, input int len);
    bit    rd_ok;
    string tag;
    rd_ok = (kind == 3) && !sel_n;
    tag   = (sel_n && kind != 0) ? "R5 load" : "R6 load";
    @(negedge clk);
    row_en_n = 1'b0; refresh_n = (kind != 0); wr_rd = (kind != 3);
    select_n = sel_n; addr = a; col_strobe_n = 1'b1;
    if (kind == 0) expq.push_back({1'b0, m_ctr});
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (kind == 2) col_strobe_n = (i != 1);
      miss_load_req = $urandom % 2;
      #1;
      check(miss_load_en == (miss_load_req & rd_ok), tag, miss_load_en, miss_load_req & rd_ok);
    end
    @(negedge clk);
    row_en_n = 1'b1; refresh_n = 1'b1; miss_load_req = 1'b0; col_strobe_n = 1'b1;
    if (kind == 1 && !sel_n) expq.push_back({1'b1, a[RW-1:0]});
    if (kind == 0) m_ctr++;
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_idle(input string req);
    repeat (6) @(negedge clk);
    check(!rf_valid && expq.size() == 0, req, rf_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    check(!rf_valid, "R10 rf_valid in reset", rf_valid, 0);
    check(!sched_req, "R10 sched_req in reset", sched_req, 0);
    miss_load_req = 1'b1; #1;
    check(!miss_load_en, "R10 load in reset", miss_load_en, 0);
    miss_load_req = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    run_cycle(0, 1'b0, 5'h00, 3);   // R2: first row is 0
    run_cycle(0, 1'b1, 5'h00, 3);   // R1: deselected refresh still counts
    run_cycle(1, 1'b0, 5'h16, 4);   // R3: top bit dropped, row 6
    run_cycle(1, 1'b0, 5'h09, 3);   // R3
    expect_idle("R3 drained");
    run_cycle(1, 1'b1, 5'h05, 4);   // R5: deselected write ignored
    expect_idle("R5 no command");
    run_cycle(2, 1'b0, 5'h03, 4);   // R4: column strobe used
    run_cycle(3, 1'b0, 5'h03, 5);   // R4/R6: read, loads pass
    expect_idle("R4 no command");
    run_cycle(3, 1'b1, 5'h03, 4);   // R5: deselected read blocks loads
    run_cycle(0, 1'b0, 5'h03, 4);   // R6: loads blocked during refresh

    rdy_rand = 1'b1;
    for (int n = 0; n < 220; n++) begin
      int k;
      k = $urandom % 4;
      sched_limit = PW'($urandom % 8);
      run_cycle(k, 1'(($urandom % 4) == 0), RW+1'($urandom), 3 + $urandom % 4);
      repeat ($urandom % 5) @(negedge clk);
    end
    rdy_rand = 1'b0;

    sched_limit = 3'd7;
    repeat (8 * PER + 10) @(negedge clk);
    check(sched_overdue && sched_req && m_pend == 7, "R8 saturated", sched_overdue, 1);
    run_cycle(0, 1'b0, 5'h00, 3);
    check(!sched_overdue, "R9 below limit", sched_overdue, 0);
    sched_limit = 3'd6; #1;
    check(sched_overdue, "R9 at limit", sched_overdue, 1);

    repeat (20) @(negedge clk);
    check(expq.size() == 0, "R7 all delivered", expq.size(), 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule